// File: doc/BRIEF.md
# Event Interrupt Aggregator with Privilege Protection

This block gathers up to 49 single-cycle hardware event pulses into sticky status bits and reduces them to two interrupt lines. The `irq` line is the maskable request: it sees only the sources that have their enable bit set. The `nmi` line is non-maskable: it sees the sources picked by a separate routing mask, whatever their enable bits say. A source can feed either line or both. The raw event pulses are also passed straight through, so a different interrupt controller can take them instead.

Software reaches the block through an AHB-Lite slave port with no wait states. Each source has six controls, each held in two 32-bit words: enable, status (read only), set (write 1 to set), clear (write 1 to clear), NMI routing and protect. When a source's protect bit is set, a write to set or clear it has effect only if the transfer is privileged (`hprot[1]`). Source 35 is reserved and stays inert.

Top module: `evt_intc`

## Requirements
- R1: A pulse on `event_in[i]` sets status bit i at the clock edge that samples it. The bit stays set until software clears it.
- R2: `event_raw` equals `event_in` in the same cycle, except that bit 35 is always 0.
- R3: `irq` is a register that holds the OR of (status AND enable) over all sources. It rises one cycle after the status bit that causes it.
- R4: `nmi` is a register that holds the OR of (status AND NMI-routing) over all sources. It does not depend on the enable bits.
- R5: A 1 written to bit b of a set word (0x10 for sources 0-31, 0x14 for sources 32-48 at bit i-32) sets that source's status bit. A 0 has no effect.
- R6: A 1 written to a clear word (0x18 / 0x1C, same bit layout) resets that source's status bit. The set and clear words read as 0.
- R7: If a hardware event and a software clear reach the same source in the same cycle, the status bit ends up set.
- R8: If a source's protect bit is set, a set or clear write with `hprot[1]`=0 leaves its status unchanged, and the same write with `hprot[1]`=1 takes effect.
- R9: A write to the protect words (0x28 / 0x2C) takes effect only when `hprot[1]`=1.
- R10: Source 35 has status 0 at all times, never drives `irq` or `nmi`, and reads 0 in every register.
- R11: The words at 0x00/0x04 (enable), 0x08/0x0C (status), 0x20/0x24 (NMI routing) and 0x28/0x2C (protect) read back their contents. Bits 17-31 of the upper words read 0, and so does every word from 0x30 to 0x5C.
- R12: After reset every register, `irq` and `nmi` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus and block clock |
| hresetn | input | 1 | Active-low asynchronous reset |
| hsel | input | 1 | Slave select |
| haddr | input | 7 | Byte address within the window |
| htrans | input | 2 | Transfer type; bit 1 marks an active transfer |
| hwrite | input | 1 | 1 for a write |
| hprot | input | 4 | Protection attribute; bit 1 marks a privileged transfer |
| hready | input | 1 | Bus ready; qualifies the address phase |
| hwdata | input | 32 | Write data, in the data phase |
| hrdata | output | 32 | Read data, in the data phase |
| event_in | input | 49 | Hardware event pulses, one per source |
| event_raw | output | 49 | Unmasked event pulses passed through |
| irq | output | 1 | Maskable interrupt, registered |
| nmi | output | 1 | Non-maskable interrupt, registered |

## Verification
Every source index is swept with three stimuli in turn: a hardware pulse with all masks off, a software set with every enable on, and a pulse with every source routed to NMI. These sweeps separate the status path, the enable gating of `irq` and the path that bypasses the enable to reach `nmi`, and they show the reserved index staying dark in all three. The privilege cases try user and privileged set and clear writes on a protected source, then on an unprotected one, so an inverted or missing protect check shows up. A clear issued in the same cycle as an event shows which of the two wins. The reads of the upper words and of the unused words expose stray bits.

// File: rtl/evt_intc.sv
module evt_intc #(
  parameter int NSRC = 49,
  parameter int RSVD = 35,
  parameter int AW   = 7
) (
  input  logic            hclk,
  input  logic            hresetn,
  input  logic            hsel,
  input  logic [AW-1:0]   haddr,
  input  logic [1:0]      htrans,
  input  logic            hwrite,
  input  logic [3:0]      hprot,
  input  logic            hready,
  input  logic [31:0]     hwdata,
  output logic [31:0]     hrdata,
  input  logic [NSRC-1:0] event_in,
  output logic [NSRC-1:0] event_raw,
  output logic            irq,
  output logic            nmi
);
  localparam logic [NSRC-1:0] VMASK = {NSRC{1'b1}} ^ (NSRC'(1) << RSVD);
  localparam int PADW = 64 - NSRC;

  logic [NSRC-1:0] en_q, status_q, nsel_q, prot_q;
  logic [AW-1:0]   addr_q;
  logic            act_q, wr_q, priv_q;

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      priv_q <= 1'b0;
      addr_q <= '0;
    end else if (hready) begin
      act_q <= hsel & htrans[1];
      if (hsel & htrans[1]) begin
        wr_q   <= hwrite;
        priv_q <= hprot[1];
        addr_q <= haddr;
      end
    end
  end

  logic [3:0]      wtype;
  logic            half;
  logic            wr;
  logic [63:0]     wd64, hm64;
  logic [NSRC-1:0] wbits, hmask, allow, set_sw, clr_sw;

  assign wtype = addr_q[AW-1:3];
  assign half  = addr_q[2];
  assign wr    = act_q & wr_q;
  assign wd64  = half ? {hwdata, 32'b0} : {32'b0, hwdata};
  assign hm64  = half ? {32'hFFFF_FFFF, 32'b0} : {32'b0, 32'hFFFF_FFFF};
  assign wbits = wd64[NSRC-1:0] & VMASK;
  assign hmask = hm64[NSRC-1:0] & VMASK;
  assign allow = priv_q ? {NSRC{1'b1}} : ~prot_q;
  assign set_sw = (wr && wtype == 4'd2) ? (wbits & allow) : '0;
  assign clr_sw = (wr && wtype == 4'd3) ? (wbits & allow) : '0;

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      en_q     <= '0;
      nsel_q   <= '0;
      prot_q   <= '0;
      status_q <= '0;
      irq      <= 1'b0;
      nmi      <= 1'b0;
    end else begin
      status_q <= ((status_q & ~clr_sw) | set_sw | event_in) & VMASK;
      if (wr && wtype == 4'd0) en_q   <= (en_q & ~hmask) | (wbits & hmask);
      if (wr && wtype == 4'd4) nsel_q <= (nsel_q & ~hmask) | (wbits & hmask);
      if (wr && priv_q && wtype == 4'd5) prot_q <= (prot_q & ~hmask) | (wbits & hmask);
      irq <= |(status_q & en_q);
      nmi <= |(status_q & nsel_q);
    end
  end

  assign event_raw = event_in & VMASK;

  logic [NSRC-1:0] rsel;
  logic [63:0]     r64;
  always_comb begin
    case (wtype)
      4'd0:    rsel = en_q;
      4'd1:    rsel = status_q;
      4'd4:    rsel = nsel_q;
      4'd5:    rsel = prot_q;
      default: rsel = '0;
    endcase
  end
  assign r64    = {{PADW{1'b0}}, rsel};
  assign hrdata = half ? r64[63:32] : r64[31:0];
endmodule

// File: rtl/evt_intc_chk.sv
module evt_intc_chk #(
  parameter int NSRC = 49,
  parameter int RSVD = 35
) (
  input logic            hclk,
  input logic            hresetn,
  input logic [NSRC-1:0] ev,
  input logic [NSRC-1:0] st,
  input logic [NSRC-1:0] en,
  input logic [NSRC-1:0] ns,
  input logic            irq,
  input logic            nmi
);
  localparam logic [NSRC-1:0] VM = {NSRC{1'b1}} ^ (NSRC'(1) << RSVD);

  p_event_sets_r1: assert property (@(posedge hclk) disable iff (!hresetn)
    ((ev & VM) != '0) |=> ((st & $past(ev & VM)) == $past(ev & VM)));

  p_irq_rise_r3: assert property (@(posedge hclk) disable iff (!hresetn)
    ((st & en) != '0) |=> irq);

  p_irq_low_r3: assert property (@(posedge hclk) disable iff (!hresetn)
    ((st & en) == '0) |=> !irq);

  p_nmi_rise_r4: assert property (@(posedge hclk) disable iff (!hresetn)
    ((st & ns) != '0) |=> nmi);

  p_rsvd_dark_r10: assert property (@(posedge hclk) disable iff (!hresetn)
    !st[RSVD]);
endmodule

bind evt_intc evt_intc_chk #(.NSRC(NSRC), .RSVD(RSVD)) u_chk (
  .hclk(hclk), .hresetn(hresetn), .ev(event_in), .st(status_q),
  .en(en_q), .ns(nsel_q), .irq(irq), .nmi(nmi));

// File: tb/evt_intc_bench.sv
module evt_intc_bench;
  localparam int TCK = 10;
  localparam int N   = 49;
  localparam int RS  = 35;

  logic          hclk = 0, hresetn = 0;
  logic          hsel = 0, hwrite = 0, hready = 1;
  logic [6:0]    haddr = '0;
  logic [1:0]    htrans = '0;
  logic [3:0]    hprot = '0;
  logic [31:0]   hwdata = '0, hrdata;
  logic [N-1:0]  event_in = '0, event_raw;
  logic          irq, nmi;
  int            n_chk = 0, n_fail = 0;
  logic [63:0]   rv;

  always #(TCK/2) hclk = ~hclk;

  evt_intc u_evt_intc (.hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr),
    .htrans(htrans), .hwrite(hwrite), .hprot(hprot), .hready(hready), .hwdata(hwdata),
    .hrdata(hrdata), .event_in(event_in), .event_raw(event_raw), .irq(irq), .nmi(nmi));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d, input logic pr,
                    input logic [N-1:0] ev_same = '0);
    @(negedge hclk);
    hsel = 1; htrans = 2'b10; hwrite = 1; haddr = a; hprot = {2'b00, pr, 1'b1};
    @(negedge hclk);
    hsel = 0; htrans = 2'b00; hwrite = 0; hwdata = d; event_in = ev_same;
    @(negedge hclk);
    event_in = '0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge hclk);
    hsel = 1; htrans = 2'b10; hwrite = 0; haddr = a; hprot = 4'b0011;
    @(negedge hclk);
    hsel = 0; htrans = 2'b00;
    d = hrdata;
  endtask

  task automatic rd64(input logic [6:0] a, output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(a, lo);
    rd(a + 7'd4, hi);
    v = {hi, lo};
  endtask

  task automatic wr64(input logic [6:0] a, input logic [63:0] v, input logic pr);
    wr(a, v[31:0], pr);
    wr(a + 7'd4, v[63:32], pr);
  endtask

  function automatic logic [63:0] bit64(input int i);
    return (i == RS) ? 64'd0 : (64'd1 << i);
  endfunction

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge hclk);
    hresetn = 1;
    @(negedge hclk);
    // R12 reset state
    rd64(7'h00, rv); chk("R12 enable", rv, 0);
    rd64(7'h08, rv); chk("R12 status", rv, 0);
    rd64(7'h28, rv); chk("R12 protect", rv, 0);
    chk("R12 irq/nmi", {62'd0, irq, nmi}, 0);

    // R1 R2 R6 R10: event sweep, masks off
    for (int i = 0; i < N; i++) begin
      @(negedge hclk);
      event_in = N'(1) << i;
      #1 chk("R2 raw", 64'(event_raw), bit64(i));
      @(negedge hclk);
      event_in = '0;
      repeat (2) @(negedge hclk);
      rd64(7'h08, rv); chk("R1 sticky", rv, bit64(i));
      chk("R3 masked irq", {63'd0, irq}, 0);
      chk("R4 unrouted nmi", {63'd0, nmi}, 0);
      wr64(7'h18, 64'd1 << i, 1'b0);
      rd64(7'h08, rv); chk("R6 clear", rv, 0);
    end

    // R11 enable readback and upper bits
    wr64(7'h00, {64{1'b1}}, 1'b0);
    rd(7'h00, w); chk("R11 enable lo", 64'(w), 64'hFFFF_FFFF);
    rd(7'h04, w); chk("R11 enable hi", 64'(w), 64'h0001_FFF7);
    rd(7'h10, w); chk("R6 set word reads 0", 64'(w), 0);
    rd(7'h1C, w); chk("R6 clear word reads 0", 64'(w), 0);
    for (int a = 'h30; a < 'h60; a += 4) begin
      rd(7'(a), w); chk("R11 unused word", 64'(w), 0);
    end

    // R3 latency on source 3
    @(negedge hclk);
    event_in = N'(1) << 3;
    @(negedge hclk);
    event_in = '0;
    chk("R3 irq not yet", {63'd0, irq}, 0);
    @(negedge hclk);
    chk("R3 irq one cycle later", {63'd0, irq}, 1);
    wr64(7'h18, 64'd1 << 3, 1'b0);
    repeat (2) @(negedge hclk);

    // R3 R5 R10: software set sweep with all enables on
    for (int i = 0; i < N; i++) begin
      wr64(7'h10, 64'd1 << i, 1'b0);
      repeat (2) @(negedge hclk);
      chk("R5/R3/R10 irq after set", {63'd0, irq}, {63'd0, i != RS});
      rd64(7'h08, rv); chk("R5 status after set", rv, bit64(i));
      wr64(7'h18, 64'd1 << i, 1'b0);
      repeat (2) @(negedge hclk);
      chk("R3 irq after clear", {63'd0, irq}, 0);
    end

    // R4: NMI path, enables off
    wr64(7'h00, 64'd0, 1'b0);
    wr64(7'h20, {64{1'b1}}, 1'b0);
    rd64(7'h20, rv); chk("R11 nmi routing readback", rv, ((64'd1 << N) - 1) & ~(64'd1 << RS));
    for (int i = 0; i < N; i++) begin
      @(negedge hclk);
      event_in = N'(1) << i;
      @(negedge hclk);
      event_in = '0;
      @(negedge hclk);
      chk("R4/R10 nmi", {63'd0, nmi}, {63'd0, i != RS});
      chk("R3 irq stays masked", {63'd0, irq}, 0);
      wr64(7'h18, 64'd1 << i, 1'b0);
      repeat (2) @(negedge hclk);
    end
    wr64(7'h20, 64'd0, 1'b0);

    // R7 event beats clear
    wr64(7'h10, 64'd1 << 7, 1'b0);
    wr(7'h18, 32'd1 << 7, 1'b0, N'(1) << 7);
    rd64(7'h08, rv); chk("R7 event wins", rv, 64'd1 << 7);
    wr64(7'h18, 64'd1 << 7, 1'b0);

    // R8 R9 protection
    wr64(7'h28, 64'd1 << 5, 1'b0);
    rd64(7'h28, rv); chk("R9 user protect write ignored", rv, 0);
    wr64(7'h28, 64'd1 << 5 | 64'd1 << 40, 1'b1);
    rd64(7'h28, rv); chk("R9 priv protect write", rv, 64'd1 << 5 | 64'd1 << 40);
    wr64(7'h28, 64'd0, 1'b0);
    rd64(7'h28, rv); chk("R9 user cannot unprotect", rv, 64'd1 << 5 | 64'd1 << 40);
    wr64(7'h10, 64'd1 << 5 | 64'd1 << 40 | 64'd1 << 6, 1'b0);
    rd64(7'h08, rv); chk("R8 user set only unprotected", rv, 64'd1 << 6);
    wr64(7'h10, 64'd1 << 5 | 64'd1 << 40, 1'b1);
    rd64(7'h08, rv); chk("R8 priv set", rv, 64'd1 << 5 | 64'd1 << 40 | 64'd1 << 6);
    wr64(7'h18, {64{1'b1}}, 1'b0);
    rd64(7'h08, rv); chk("R8 user clear skips protected", rv, 64'd1 << 5 | 64'd1 << 40);
    wr64(7'h18, {64{1'b1}}, 1'b1);
    rd64(7'h08, rv); chk("R8 priv clear", rv, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge hclk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule